// File: doc/BRIEF.md
# UART Channel Host Control with Mode Pointer and Receive FIFO

This block is the host-facing control section of one serial channel. It holds two mode registers that share a single host address. An internal pointer selects which one a write reaches: after reset the first write lands in mode register 1, and every later write lands in mode register 2 until a command moves the pointer back. A command register turns the receiver and the transmitter on and off and issues pointer, receiver, transmitter and error-flag resets. A clock-select register holds a baud code, and the block decodes that code into a small rate index for an external baud generator.

Characters delivered by an external receive shifter are queued in a holding FIFO that is four entries deep. Each read of the receive buffer address pops one entry. A single transmit holding register passes bytes to an external transmit shifter. The status byte reports:
- receiver ready
- FIFO full
- transmitter ready
- transmitter empty
- overrun
- received break

An interrupt mask register selects which channel events drive the interrupt request.

Host register map, by 3-bit address:

| Address | Read | Write |
|---|---|---|
| 0 | mode register selected by the pointer | mode register selected by the pointer |
| 1 | status byte | clock-select register |
| 2 | clock-select register | command |
| 3 | receive buffer | transmit holding register |
| 4 | interrupt status in bits 3:0 | interrupt mask in bits 3:0 |

Any other address reads as 0. `host_rdata` is a combinational function of `host_addr` and the current state. A read has a side effect only at address 3.

Top module: `uart_chan_ctrl`

## Requirements
- R1: The mode pointer points at mode register 1 after reset. A write to address 0 while it points at mode register 1 loads mode register 1 and advances the pointer. Writes to address 0 while it points at mode register 2 load mode register 2, and the pointer stays there. A read of address 0 returns the register the pointer selects. `mode1_cfg` and `mode2_cfg` always show both registers.
- R2: A command write with bits 6:4 = 001 returns the pointer to mode register 1. The registers keep their contents.
- R3: In a command write, bits 1:0 control the receiver and bits 3:2 control the transmitter: 01 enables, 10 disables, and 00 or 11 leaves the state unchanged. So 0x05 enables both and 0x0A disables both. Both are disabled after reset.
- R4: Command bits 6:4 = 010 empty the FIFO, clear the overrun and break flags, and disable the receiver. Command bits 6:4 = 011 discard the transmit holding byte and disable the transmitter. Each reset overrides the enable bits in the same write.
- R5: Status bit 0 (receiver ready) is 1 whenever the FIFO holds at least one character. Status bit 1 (FIFO full) is 1 when four characters are waiting. Bits 6:5 read 0.
- R6: A read of address 3 returns the oldest queued character and removes it. A read of address 3 while the FIFO is empty returns 0 and changes nothing.
- R7: A character presented while the receiver is disabled is ignored. A character arriving while the FIFO is full is dropped and sets status bit 4 (overrun), unless a pop happens in the same cycle, in which case the character is queued. Command bits 6:4 = 100 clear the overrun and break flags, and a new event in the same cycle wins over that clear.
- R8: Status bit 2 (transmitter ready) is 1 when the transmitter is enabled and the holding register is empty. A write to address 3 is accepted only when transmitter ready is 1. An accepted byte appears on `tx_hold_data` with `tx_hold_valid` high until `tx_take` is pulsed.
- R9: Status bit 3 (transmitter empty) is 1 when the holding register is empty and `tx_busy` is low.
- R10: A `rx_break` pulse while the receiver is enabled sets status bit 7. Only the error reset and the receiver reset clear it.
- R11: `baud_sel` decodes the clock-select register as follows. Any other code gives 0.

  | Code | `baud_sel` | Rate |
  |---|---|---|
  | 0x55 | 1 | 300 baud |
  | 0x66 | 2 | 1200 baud |
  | 0x88 | 3 | 2400 baud |
  | 0x99 | 4 | 4800 baud |
  | 0xBB | 5 | 9600 baud |
  | 0xCC | 6 | 19200 baud |

- R12: Interrupt status bits are: bit 0 transmitter ready, bit 1 receiver ready, bit 2 break, bit 3 overrun. `irq` is 1 exactly when some interrupt status bit and the matching mask bit are both 1. The mask is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops the FIFO at address 3) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| rx_char_valid | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | Receive shifter detected a break |
| tx_take | input | 1 | Transmit shifter takes the holding byte |
| tx_busy | input | 1 | Transmit shifter is sending |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| mode1_cfg | output | 8 | Mode register 1 contents |
| mode2_cfg | output | 8 | Mode register 2 contents |
| baud_sel | output | 3 | Decoded baud rate index |
| tx_hold_valid | output | 1 | Holding register contains a byte |
| tx_hold_data | output | 8 | Holding register byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a full FIFO that receives a character in the same cycle as a host pop. There the new character must be queued without raising overrun. Reaching it requires clearing a previous overrun, refilling the FIFO to exactly four entries, and then driving `rx_char_valid` and a read of address 3 in the same cycle.

The bench steers into that cycle with directed stimulus. It also mixes pointer resets between mode writes, and receiver or transmitter resets issued while data is pending. A randomized phase then drives all inputs together against a queue-based model that is compared on every clock.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE  = 3'd0,
        REG_STAT  = 3'd1,
        REG_CMD   = 3'd2,
        REG_DATA  = 3'd3,
        REG_INT   = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        MISC_NONE    = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4
    } misc_cmd_e;

    localparam logic [1:0] CTL_ON  = 2'b01;
    localparam logic [1:0] CTL_OFF = 2'b10;

    function automatic logic [2:0] baud_index(input logic [BYTE_W-1:0] code);
        logic [2:0] idx;
        case (code)
            8'h55:   idx = 3'd1;
            8'h66:   idx = 3'd2;
            8'h88:   idx = 3'd3;
            8'h99:   idx = 3'd4;
            8'hBB:   idx = 3'd5;
            8'hCC:   idx = 3'd6;
            default: idx = 3'd0;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/uart_mode_ptr.sv
module uart_mode_ptr
    import uart_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [BYTE_W-1:0] mode_wdata,
    input  logic              ptr_rst,
    output logic [BYTE_W-1:0] mode1,
    output logic [BYTE_W-1:0] mode2,
    output logic              ptr_at_mr2
);

    typedef struct packed {
        logic [BYTE_W-1:0] mr1;
        logic [BYTE_W-1:0] mr2;
        logic              sel;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ptr_rst) begin
            st_d.sel = 1'b0;
        end
        if (mode_wr) begin
            if (!st_q.sel) begin
                st_d.mr1 = mode_wdata;
                st_d.sel = 1'b1;
            end else begin
                st_d.mr2 = mode_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode1      = st_q.mr1;
    assign mode2      = st_q.mr2;
    assign ptr_at_mr2 = st_q.sel;

    // R1: a write through the pointer at register 1 moves it on to register 2
    assert_ptr_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !ptr_at_mr2 && !ptr_rst) |=> ptr_at_mr2);

    // R1: once at register 2, writes land there and leave register 1 alone
    assert_mr2_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && ptr_at_mr2) |=> (mode2 == $past(mode_wdata)) && $stable(mode1));

    // R2: the pointer reset command returns to register 1
    assert_ptr_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_rst && !mode_wr) |=> !ptr_at_mr2);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_chan_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    input  logic              clr,
    input  logic              err_clr,
    input  logic              brk_set,
    output logic [BYTE_W-1:0] head_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              overrun,
    output logic              brk_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rp;
        logic [PTR_W-1:0] wp;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
        logic             brk;
    } fifo_st_t;

    fifo_st_t          st_d, st_q;
    logic [BYTE_W-1:0] mem_d [DEPTH];
    logic [BYTE_W-1:0] mem_q [DEPTH];

    logic do_pop, do_push, drop;

    always_comb begin
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != FULL_CNT) || do_pop);
        drop    = push && !do_push;

        st_d  = st_q;
        mem_d = mem_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                mem_d[st_q.wp] = push_data;
                st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + PTR_W'(1);
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + PTR_W'(1);
            end
            st_d.cnt = st_q.cnt + (do_push ? CNT_W'(1) : '0) - (do_pop ? CNT_W'(1) : '0);
            if (err_clr) begin
                st_d.ovr = 1'b0;
                st_d.brk = 1'b0;
            end
            if (drop) begin
                st_d.ovr = 1'b1;
            end
            if (brk_set) begin
                st_d.brk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign head_data = mem_q[st_q.rp];
    assign count     = st_q.cnt;
    assign overrun   = st_q.ovr;
    assign brk_flag  = st_q.brk;

    // R7: a character arriving at a full FIFO with no pop is lost and flags overrun
    assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == FULL_CNT && !pop && !clr) |=> (count == FULL_CNT) && overrun);

    // R6: a pop without a push takes exactly one entry away
    assert_pop_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0 && !push && !clr) |=> (count == $past(count) - CNT_W'(1)));

    // R4: the receiver reset leaves an empty FIFO with no error flags
    assert_clr_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && !overrun && !brk_flag);

    // R5: the count never exceeds the depth
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_wr,
    input  logic [BYTE_W-1:0] hold_wdata,
    input  logic              take,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              tx_rst,
    output logic              tx_en,
    output logic              hold_valid,
    output logic [BYTE_W-1:0] hold_data,
    output logic              ready
);

    typedef struct packed {
        logic              en;
        logic              valid;
        logic [BYTE_W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_clr) begin
            st_d.en = 1'b0;
        end else if (en_set) begin
            st_d.en = 1'b1;
        end
        if (tx_rst) begin
            st_d.valid = 1'b0;
        end else if (take && st_q.valid) begin
            st_d.valid = 1'b0;
        end else if (hold_wr && st_q.en && !st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.data  = hold_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_en      = st_q.en;
    assign hold_valid = st_q.valid;
    assign hold_data  = st_q.data;
    assign ready      = st_q.en && !st_q.valid;

    // R8: a write refused by the holding register leaves its byte untouched
    assert_drop_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_wr && !ready) |=> $stable(hold_data));

    // R8: the shifter taking the byte empties the holding register
    assert_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && hold_valid) |=> !hold_valid);

    // R4: the transmitter reset discards the byte and disables the transmitter
    assert_tx_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> !hold_valid && !tx_en);

endmodule

// File: rtl/uart_irq.sv
module uart_irq #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic [N_SRC-1:0] events,
    output logic [N_SRC-1:0] isr,
    output logic             irq
);

    typedef struct packed {
        logic [N_SRC-1:0] imr;
    } irq_st_t;

    irq_st_t          st_d, st_q;
    logic [N_SRC-1:0] hits;

    always_comb begin
        st_d = st_q;
        if (mask_wr) begin
            st_d.imr = mask_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            assign hits[i] = events[i] & st_q.imr[i];
        end
    endgenerate

    assign isr = events;
    assign irq = |hits;

    // R12: with the whole mask clear, after a cleared-mask write, no request
    assert_mask_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata == '0) |=> !irq);

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import uart_chan_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        rx_char_valid,
    input  logic [7:0]  rx_char,
    input  logic        rx_break,
    input  logic        tx_take,
    input  logic        tx_busy,
    output logic        rx_enable,
    output logic        tx_enable,
    output logic [7:0]  mode1_cfg,
    output logic [7:0]  mode2_cfg,
    output logic [2:0]  baud_sel,
    output logic        tx_hold_valid,
    output logic [7:0]  tx_hold_data,
    output logic        irq
);

    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int N_IRQ  = 4;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    typedef struct packed {
        logic              rx_en;
        logic [BYTE_W-1:0] csr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic      wr_mode, wr_csr, wr_cmd, wr_data, wr_mask, rd_pop;
    logic [1:0] rx_ctl, tx_ctl;
    misc_cmd_e misc;
    logic      cmd_ptr_rst, cmd_rx_rst, cmd_tx_rst, cmd_err_rst;

    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              ovr_flag, brk_flag;
    logic              ptr_at_mr2;
    logic              tx_ready;
    logic [N_IRQ-1:0]  isr;
    logic              rx_ready, fifo_full, tx_empty;
    logic [BYTE_W-1:0] status;

    // host decode
    always_comb begin
        wr_mode = host_wr && (host_addr == REG_MODE);
        wr_csr  = host_wr && (host_addr == REG_STAT);
        wr_cmd  = host_wr && (host_addr == REG_CMD);
        wr_data = host_wr && (host_addr == REG_DATA);
        wr_mask = host_wr && (host_addr == REG_INT);
        rd_pop  = host_rd && (host_addr == REG_DATA);
        rx_ctl  = host_wdata[1:0];
        tx_ctl  = host_wdata[3:2];
        misc    = misc_cmd_e'(host_wdata[6:4]);
        cmd_ptr_rst = wr_cmd && (misc == MISC_PTR_RST);
        cmd_rx_rst  = wr_cmd && (misc == MISC_RX_RST);
        cmd_tx_rst  = wr_cmd && (misc == MISC_TX_RST);
        cmd_err_rst = wr_cmd && (misc == MISC_ERR_RST);
    end

    // receiver enable and clock select
    always_comb begin
        st_d = st_q;
        if (wr_csr) begin
            st_d.csr = host_wdata;
        end
        if (wr_cmd) begin
            if (rx_ctl == CTL_ON) begin
                st_d.rx_en = 1'b1;
            end else if (rx_ctl == CTL_OFF) begin
                st_d.rx_en = 1'b0;
            end
        end
        if (cmd_rx_rst) begin
            st_d.rx_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    uart_mode_ptr u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (wr_mode),
        .mode_wdata (host_wdata),
        .ptr_rst    (cmd_ptr_rst),
        .mode1      (mode1_cfg),
        .mode2      (mode2_cfg),
        .ptr_at_mr2 (ptr_at_mr2)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_char_valid && st_q.rx_en),
        .push_data (rx_char),
        .pop       (rd_pop),
        .clr       (cmd_rx_rst),
        .err_clr   (cmd_err_rst),
        .brk_set   (rx_break && st_q.rx_en),
        .head_data (fifo_head),
        .count     (fifo_cnt),
        .overrun   (ovr_flag),
        .brk_flag  (brk_flag)
    );

    uart_tx_hold u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_wr    (wr_data),
        .hold_wdata (host_wdata),
        .take       (tx_take),
        .en_set     (wr_cmd && tx_ctl == CTL_ON),
        .en_clr     ((wr_cmd && tx_ctl == CTL_OFF) || cmd_tx_rst),
        .tx_rst     (cmd_tx_rst),
        .tx_en      (tx_enable),
        .hold_valid (tx_hold_valid),
        .hold_data  (tx_hold_data),
        .ready      (tx_ready)
    );

    always_comb begin
        rx_ready  = (fifo_cnt != '0);
        fifo_full = (fifo_cnt == FULL_CNT);
        tx_empty  = !tx_hold_valid && !tx_busy;
        status    = {brk_flag, 2'b00, ovr_flag, tx_empty, tx_ready, fifo_full, rx_ready};
    end

    uart_irq #(.N_SRC(N_IRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (wr_mask),
        .mask_wdata (host_wdata[N_IRQ-1:0]),
        .events     ({ovr_flag, brk_flag, rx_ready, tx_ready}),
        .isr        (isr),
        .irq        (irq)
    );

    // read mux
    always_comb begin
        case (host_addr)
            REG_MODE: host_rdata = ptr_at_mr2 ? mode2_cfg : mode1_cfg;
            REG_STAT: host_rdata = status;
            REG_CMD:  host_rdata = st_q.csr;
            REG_DATA: host_rdata = rx_ready ? fifo_head : '0;
            REG_INT:  host_rdata = {{(BYTE_W-N_IRQ){1'b0}}, isr};
            default:  host_rdata = '0;
        endcase
    end

    assign rx_enable = st_q.rx_en;
    assign baud_sel  = baud_index(st_q.csr);

    // R7: while the receiver is off and nobody pops or resets, the FIFO is frozen
    assert_rx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rd_pop && !cmd_rx_rst) |=> $stable(fifo_cnt));

    // R3: an enable command for the receiver takes effect on the next cycle
    assert_rx_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && rx_ctl == CTL_ON && !cmd_rx_rst) |=> rx_enable);

    // R10: a break seen by an enabled receiver raises the break flag
    assert_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && rx_enable && !cmd_rx_rst) |=> brk_flag);

endmodule

// File: tb/uart_chan_ctrl_tb.sv
module uart_chan_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_char_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_break = 1'b0, tx_take = 1'b0, tx_busy = 1'b0;
    logic       rx_enable, tx_enable, tx_hold_valid, irq;
    logic [7:0] mode1_cfg, mode2_cfg, tx_hold_data;
    logic [2:0] baud_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_chan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_char_valid(rx_char_valid), .rx_char(rx_char), .rx_break(rx_break),
        .tx_take(tx_take), .tx_busy(tx_busy), .rx_enable(rx_enable),
        .tx_enable(tx_enable), .mode1_cfg(mode1_cfg), .mode2_cfg(mode2_cfg),
        .baud_sel(baud_sel), .tx_hold_valid(tx_hold_valid),
        .tx_hold_data(tx_hold_data), .irq(irq)
    );

    // reference model state
    bit         m_ptr, m_rx_en, m_tx_en, m_ovr, m_brk, m_hv;
    logic [7:0] m_mr1, m_mr2, m_csr, m_hd;
    logic [3:0] m_imr;
    logic [7:0] m_q[$];

    task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_isr();
        return {m_ovr, m_brk, m_q.size() > 0, m_tx_en && !m_hv};
    endfunction

    function automatic logic [7:0] m_status();
        return {m_brk, 2'b00, m_ovr, !m_hv && !tx_busy, m_tx_en && !m_hv,
                m_q.size() == 4, m_q.size() > 0};
    endfunction

    function automatic logic [2:0] m_baud(input logic [7:0] c);
        if (c == 8'h55) return 3'd1;
        if (c == 8'h66) return 3'd2;
        if (c == 8'h88) return 3'd3;
        if (c == 8'h99) return 3'd4;
        if (c == 8'hBB) return 3'd5;
        if (c == 8'hCC) return 3'd6;
        return 3'd0;
    endfunction

    function automatic logic [7:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ptr ? m_mr2 : m_mr1;
            3'd1: return m_status();
            3'd2: return m_csr;
            3'd3: return (m_q.size() > 0) ? m_q[0] : 8'h00;
            3'd4: return {4'h0, m_isr()};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R1 rdata mode";
            3'd1: return "R5 rdata status";
            3'd2: return "R11 rdata clock-select";
            3'd3: return "R6 rdata rx buffer";
            default: return "R12 rdata interrupt";
        endcase
    endfunction

    task automatic compare_all();
        expect8(rd_tag(host_addr), host_rdata, m_rd(host_addr));
        expect8("R12 irq", {7'd0, irq}, {7'd0, |(m_isr() & m_imr)});
        expect8("R3 rx_enable", {7'd0, rx_enable}, {7'd0, m_rx_en});
        expect8("R3 tx_enable", {7'd0, tx_enable}, {7'd0, m_tx_en});
        expect8("R1 mode1", mode1_cfg, m_mr1);
        expect8("R1 mode2", mode2_cfg, m_mr2);
        expect8("R11 baud_sel", {5'd0, baud_sel}, {5'd0, m_baud(m_csr)});
        expect8("R8 tx_hold_valid", {7'd0, tx_hold_valid}, {7'd0, m_hv});
        if (m_hv) expect8("R8 tx_hold_data", tx_hold_data, m_hd);
    endtask

    task automatic model_step();
        bit   pop, full, cmd, rx_rst, tx_rst, err_rst, drop, n_rx_en, n_tx_en;
        logic [1:0] rc, tc;
        pop  = host_rd && host_addr == 3'd3 && m_q.size() > 0;
        full = m_q.size() == 4;
        cmd  = host_wr && host_addr == 3'd2;
        rc = host_wdata[1:0];
        tc = host_wdata[3:2];
        rx_rst  = cmd && host_wdata[6:4] == 3'd2;
        tx_rst  = cmd && host_wdata[6:4] == 3'd3;
        err_rst = cmd && host_wdata[6:4] == 3'd4;
        drop = 1'b0;
        n_rx_en = m_rx_en;
        n_tx_en = m_tx_en;
        if (cmd && rc == 2'b01) n_rx_en = 1'b1;
        if (cmd && rc == 2'b10) n_rx_en = 1'b0;
        if (rx_rst) n_rx_en = 1'b0;
        if (cmd && tc == 2'b01) n_tx_en = 1'b1;
        if ((cmd && tc == 2'b10) || tx_rst) n_tx_en = 1'b0;
        // transmit holding register
        if (tx_rst) m_hv = 1'b0;
        else if (tx_take && m_hv) m_hv = 1'b0;
        else if (host_wr && host_addr == 3'd3 && m_tx_en && !m_hv) begin
            m_hv = 1'b1;
            m_hd = host_wdata;
        end
        // receive queue and flags
        if (pop) void'(m_q.pop_front());
        if (rx_char_valid && m_rx_en) begin
            if (!full || pop) m_q.push_back(rx_char);
            else drop = 1'b1;
        end
        if (err_rst) begin
            m_ovr = 1'b0;
            m_brk = 1'b0;
        end
        if (drop) m_ovr = 1'b1;
        if (rx_break && m_rx_en) m_brk = 1'b1;
        if (rx_rst) begin
            m_q.delete();
            m_ovr = 1'b0;
            m_brk = 1'b0;
        end
        // mode pointer
        if (cmd && host_wdata[6:4] == 3'd1) m_ptr = 1'b0;
        if (host_wr && host_addr == 3'd0) begin
            if (!m_ptr) begin
                m_mr1 = host_wdata;
                m_ptr = 1'b1;
            end else begin
                m_mr2 = host_wdata;
            end
        end
        if (host_wr && host_addr == 3'd1) m_csr = host_wdata;
        if (host_wr && host_addr == 3'd4) m_imr = host_wdata[3:0];
        m_rx_en = n_rx_en;
        m_tx_en = n_tx_en;
    endtask

    // one clock: inputs already set at the falling edge
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; rx_char_valid = 0; rx_break = 0; tx_take = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        tick();
        idle();
    endtask

    task automatic rd(input logic [2:0] a);
        host_rd = 1; host_addr = a;
        tick();
        idle();
    endtask

    task automatic rxc(input logic [7:0] d);
        rx_char_valid = 1; rx_char = d;
        tick();
        idle();
    endtask

    task automatic look(input logic [2:0] a, input string tag, input logic [7:0] exp);
        host_addr = a;
        #1;
        expect8(tag, host_rdata, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [8] = '{8'h55, 8'h66, 8'h88, 8'h99, 8'hBB, 8'hCC, 8'h77, 8'h00};
        logic [2:0] idxs  [8] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd0, 3'd0};
        m_ptr = 0; m_rx_en = 0; m_tx_en = 0; m_ovr = 0; m_brk = 0; m_hv = 0;
        m_mr1 = 0; m_mr2 = 0; m_csr = 0; m_hd = 0; m_imr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        look(3'd1, "R9 reset status", 8'h08);
        look(3'd0, "R1 reset mode read", 8'h00);
        expect8("R12 reset irq", {7'd0, irq}, 8'h00);
        // mode pointer
        wr(3'd0, 8'h13);
        wr(3'd0, 8'h07);
        look(3'd0, "R1 read at mode2", 8'h07);
        wr(3'd0, 8'h27);
        expect8("R1 mode1 kept", mode1_cfg, 8'h13);
        expect8("R1 mode2 reload", mode2_cfg, 8'h27);
        wr(3'd2, 8'h10);
        look(3'd0, "R2 pointer back to mode1", 8'h13);
        wr(3'd0, 8'h93);
        expect8("R2 mode1 rewritten", mode1_cfg, 8'h93);
        expect8("R2 mode2 untouched", mode2_cfg, 8'h27);
        // receiver disabled ignores input
        rxc(8'hAA);
        look(3'd1, "R7 char ignored while disabled", 8'h08);
        wr(3'd2, 8'h05);
        expect8("R3 both enabled", {6'd0, rx_enable, tx_enable}, 8'h03);
        look(3'd1, "R8 tx ready when enabled", 8'h0C);
        // fill and overrun
        rxc(8'h11); rxc(8'h22); rxc(8'h33); rxc(8'h44);
        look(3'd1, "R5 four waiting sets full", 8'h0F);
        rxc(8'h55);
        look(3'd1, "R7 fifth char sets overrun", 8'h1F);
        look(3'd3, "R6 oldest first", 8'h11);
        rd(3'd3);
        look(3'd3, "R6 pop advances", 8'h22);
        rxc(8'h66);
        wr(3'd2, 8'h40);
        look(3'd1, "R7 error reset clears overrun", 8'h0F);
        // full with simultaneous pop and push
        host_rd = 1; host_addr = 3'd3; rx_char_valid = 1; rx_char = 8'h77;
        tick();
        idle();
        look(3'd1, "R7 push with pop at full no overrun", 8'h0F);
        look(3'd3, "R6 after push-pop", 8'h33);
        rd(3'd3); rd(3'd3); rd(3'd3);
        look(3'd3, "R7 pushed char kept", 8'h77);
        rd(3'd3);
        look(3'd3, "R6 empty read returns zero", 8'h00);
        rd(3'd3);
        look(3'd1, "R6 empty read no effect", 8'h0C);
        // transmitter
        wr(3'd3, 8'hA5);
        expect8("R8 holding byte", tx_hold_data, 8'hA5);
        look(3'd1, "R9 not empty with byte", 8'h00);
        wr(3'd3, 8'h5A);
        expect8("R8 refused write keeps byte", tx_hold_data, 8'hA5);
        tx_take = 1; tx_busy = 1;
        tick();
        idle();
        look(3'd1, "R9 busy shifter not empty", 8'h04);
        tx_busy = 0;
        look(3'd1, "R9 idle shifter empty", 8'h0C);
        wr(3'd2, 8'h08);
        look(3'd1, "R8 disabled tx not ready", 8'h08);
        wr(3'd3, 8'h99);
        expect8("R8 write while disabled dropped", {7'd0, tx_hold_valid}, 8'h00);
        wr(3'd2, 8'h04);
        wr(3'd3, 8'h3C);
        wr(3'd2, 8'h34);
        expect8("R4 tx reset beats enable", {6'd0, tx_enable, tx_hold_valid}, 8'h00);
        // break and receiver reset
        rx_break = 1;
        tick();
        idle();
        look(3'd1, "R10 break flag", 8'h88);
        wr(3'd2, 8'h40);
        look(3'd1, "R7 error reset clears break", 8'h08);
        rxc(8'h01); rxc(8'h02);
        rx_break = 1;
        tick();
        idle();
        wr(3'd2, 8'h21);
        expect8("R4 rx reset beats enable", {7'd0, rx_enable}, 8'h00);
        look(3'd1, "R4 rx reset empties", 8'h08);
        // clock select
        for (int i = 0; i < 8; i++) begin
            wr(3'd1, codes[i]);
            expect8("R11 baud decode", {5'd0, baud_sel}, {5'd0, idxs[i]});
        end
        look(3'd2, "R11 code readback", 8'h00);
        // interrupts
        wr(3'd2, 8'h05);
        expect8("R12 masked irq low", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h01);
        expect8("R12 tx ready irq", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'h02);
        expect8("R12 rx mask no data", {7'd0, irq}, 8'h00);
        rxc(8'hEE);
        expect8("R12 rx ready irq", {7'd0, irq}, 8'h01);
        look(3'd4, "R12 isr bits", 8'h03);
        rd(3'd3);
        expect8("R12 irq after pop", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h0A);
        expect8("R3 both disabled", {6'd0, rx_enable, tx_enable}, 8'h00);
        // randomized phase against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            host_wr = (r < 30);
            host_rd = (r >= 30 && r < 50);
            host_addr = 3'($urandom_range(0, 5));
            host_wdata = 8'($urandom);
            if (host_wr && host_addr == 3'd2 && $urandom_range(0, 3) != 0)
                host_wdata = {1'b0, 3'($urandom_range(0, 4)), 2'($urandom), 2'($urandom)};
            rx_char_valid = ($urandom_range(0, 2) == 0);
            rx_char = 8'($urandom);
            rx_break = ($urandom_range(0, 30) == 0);
            tx_take = ($urandom_range(0, 3) == 0);
            tx_busy = ($urandom_range(0, 1) == 0);
            tick();
        end
        idle();
        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule